// File: doc/BRIEF.md
# Width-Selectable Segment Row Stager

This block builds one row of column (segment) drive data for a panel up to 64 columns wide. Display memory supplies the row one byte at a time. A 3-bit width select sets how many 8-bit staging lanes are in use, from one lane (8 columns) up to eight lanes (64 columns). The block places each accepted byte into the next lane in use. It raises a full flag once the last lane in use has been loaded.

At a row boundary, if the staging set is full, the block copies all staged lanes in one step into a 64-bit drive register that feeds the segment outputs. Segments above the selected width read low. The byte index output tells the memory side which byte of the row to fetch next. The width select is sampled only at row boundaries, so a change made in the middle of a row applies from the next row.

Top module: `seg_row_stager`

## Requirements
- R1: After reset, seg_out is all zero, byte_idx is 0 and stage_full is 0. The active width is eight lanes (64 columns), the same as width_sel = 7.
- R2: A byte is accepted in a cycle where byte_valid is 1 and both stage_full and row_strobe are 0. It is stored in lane byte_idx, which covers seg_out bits [8*byte_idx+7 : 8*byte_idx] after transfer. byte_idx rises by one after each accepted byte, except after the last lane in use.
- R3: When the accepted byte lands in the last lane in use (byte_idx equal to the active select S), stage_full becomes 1 on the next cycle and byte_idx stays at S.
- R4: While stage_full is 1, byte_valid has no effect. Extra bytes do not alter the staged lanes or the next transfer.
- R5: A row_strobe while stage_full is 1 loads seg_out on that clock edge with lanes 0..S, lane k placed at bits [8k+7:8k]. In the same edge, stage_full clears and byte_idx returns to 0.
- R6: A row_strobe while stage_full is 0 leaves seg_out unchanged and returns byte_idx to 0. Bytes from the partial row are discarded.
- R7: width_sel is captured only on a row_strobe edge. The captured value S sets the row that follows: S+1 bytes fill it. Changes to width_sel between strobes have no effect on the row in progress.
- R8: When row_strobe and byte_valid are 1 in the same cycle, the strobe takes priority and the byte is dropped.
- R9: seg_out bits at and above 8*(S+1), for the width S of the row last transferred, are 0. This holds even when a wider earlier row left data in those lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_in | input | 8 | Row data byte from display memory |
| byte_valid | input | 1 | byte_in is valid this cycle |
| width_sel | input | 3 | Lanes in use minus one, captured at row_strobe |
| row_strobe | input | 1 | Row boundary: transfer if full, then start a new row |
| byte_idx | output | 3 | Index of the next lane to load (memory byte address) |
| stage_full | output | 1 | All lanes in use hold data for this row |
| seg_out | output | 64 | Segment drive data |

## Verification
A wrong byte index shows up in two ways at the next transfer: bytes land in shifted lanes, or stage_full rises after too few or too many bytes. The full flag shows this one cycle after the byte that should have completed the row. A stale active width or a missing mask shows as nonzero upper segments on the first strobe after a row narrows. A lane that loads while full corrupts the following transfer. The bench compares every transfer, and every held value, against a queue of expected words on the cycle after each strobe.

// File: rtl/seg_stage_pkg.sv
package seg_stage_pkg;
  localparam int unsigned DEF_LANE_W = 8;
  localparam int unsigned DEF_LANES  = 8;

  typedef enum logic [0:0] {ROW_FILLING = 1'b0, ROW_COMPLETE = 1'b1} row_state_e;
endpackage

// File: rtl/stage_index_ctrl.sv
module stage_index_ctrl #(
  parameter int unsigned LANES = 8,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             row_strobe,
  input  logic [SEL_W-1:0] width_sel,
  output logic [SEL_W-1:0] idx_q,
  output logic [SEL_W-1:0] active_sel,
  output logic             byte_load,
  output logic             xfer_go,
  output logic             full_q
);
  import seg_stage_pkg::*;

  row_state_e state_q;

  function automatic logic is_last(input logic [SEL_W-1:0] idx,
                                   input logic [SEL_W-1:0] sel);
    return idx == sel;
  endfunction

  assign full_q    = (state_q == ROW_COMPLETE);
  assign byte_load = byte_valid && !row_strobe && !full_q;
  assign xfer_go   = row_strobe && full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      active_sel <= SEL_W'(LANES - 1);
      state_q    <= ROW_FILLING;
    end else if (row_strobe) begin
      idx_q      <= '0;
      active_sel <= width_sel;
      state_q    <= ROW_FILLING;
    end else if (byte_load) begin
      if (is_last(idx_q, active_sel)) state_q <= ROW_COMPLETE;
      else                            idx_q   <= idx_q + 1'b1;
    end
  end

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= active_sel);
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !row_strobe) |=> (full_q && $stable(idx_q)));
  assert_strobe_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_strobe |=> (!full_q && idx_q == '0));
  assert_sel_only_at_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !row_strobe |=> $stable(active_sel));
endmodule

// File: rtl/stage_lane_bank.sv
module stage_lane_bank #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned SEL_W = $clog2(LANES),
  localparam int unsigned SEG_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_load,
  input  logic              full_q,
  input  logic              row_strobe,
  input  logic [SEL_W-1:0]  idx_q,
  input  logic [LANE_W-1:0] byte_in,
  output logic [SEG_W-1:0]  staged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    wire lane_we = byte_load && (idx_q == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_we) lane_q <= byte_in;
    end

    assign staged[g*LANE_W +: LANE_W] = lane_q;
  end

  assert_no_load_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !row_strobe) |=> $stable(staged));
endmodule

// File: rtl/drive_latch.sv
module drive_latch #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned SEL_W = $clog2(LANES),
  localparam int unsigned SEG_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_go,
  input  logic             row_strobe,
  input  logic [SEL_W-1:0] active_sel,
  input  logic [SEG_W-1:0] staged,
  output logic [SEG_W-1:0] seg_q
);
  logic [SEL_W-1:0] shown_sel;

  function automatic logic [SEG_W-1:0] seg_mask(input logic [SEL_W-1:0] sel);
    logic [SEG_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++)
      if (k <= int'(sel)) m[k*LANE_W +: LANE_W] = '1;
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= '0;
      shown_sel <= SEL_W'(LANES - 1);
    end else if (xfer_go) begin
      seg_q     <= staged & seg_mask(active_sel);
      shown_sel <= active_sel;
    end
  end

  assert_hold_when_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe && !xfer_go) |=> $stable(seg_q));
  assert_upper_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q & ~seg_mask(shown_sel)) == '0);
endmodule

// File: rtl/seg_row_stager.sv
module seg_row_stager #(
  parameter int unsigned LANE_W = seg_stage_pkg::DEF_LANE_W,
  parameter int unsigned LANES  = seg_stage_pkg::DEF_LANES,
  localparam int unsigned SEL_W = $clog2(LANES),
  localparam int unsigned SEG_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] byte_in,
  input  logic              byte_valid,
  input  logic [SEL_W-1:0]  width_sel,
  input  logic              row_strobe,
  output logic [SEL_W-1:0]  byte_idx,
  output logic              stage_full,
  output logic [SEG_W-1:0]  seg_out
);
  logic [SEL_W-1:0] active_sel;
  logic             byte_load;
  logic             xfer_go;
  logic [SEG_W-1:0] staged;

  stage_index_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .row_strobe(row_strobe),
    .width_sel(width_sel), .idx_q(byte_idx), .active_sel(active_sel),
    .byte_load(byte_load), .xfer_go(xfer_go), .full_q(stage_full)
  );

  stage_lane_bank #(.LANE_W(LANE_W), .LANES(LANES)) u_bank (
    .clk(clk), .rst_n(rst_n), .byte_load(byte_load), .full_q(stage_full),
    .row_strobe(row_strobe), .idx_q(byte_idx), .byte_in(byte_in), .staged(staged)
  );

  drive_latch #(.LANE_W(LANE_W), .LANES(LANES)) u_drive (
    .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .row_strobe(row_strobe),
    .active_sel(active_sel), .staged(staged), .seg_q(seg_out)
  );

  assert_dropped_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe && byte_valid) |=> (byte_idx == '0 && !stage_full));
endmodule

// File: tb/seg_row_stager_tb.sv
module seg_row_stager_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        byte_valid = 1'b0;
  logic [2:0]  width_sel = 3'd7;
  logic        row_strobe = 1'b0;
  logic [2:0]  byte_idx;
  logic        stage_full;
  logic [63:0] seg_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state, written from the requirements
  logic [7:0]  m_lane [8];
  int          m_idx = 0;
  int          m_sel = 7;
  bit          m_full = 0;
  logic [63:0] m_drive = '0;
  logic [63:0] exp_q [$];

  always #10 clk = ~clk;

  seg_row_stager u_dut (
    .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_valid(byte_valid),
    .width_sel(width_sel), .row_strobe(row_strobe), .byte_idx(byte_idx),
    .stage_full(stage_full), .seg_out(seg_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_ctrl(input string tag);
    chk({tag, " byte_idx"}, 64'(byte_idx), 64'(m_idx));
    chk({tag, " stage_full"}, 64'(stage_full), 64'(m_full));
  endtask

  task automatic push_byte(input logic [7:0] b);
    byte_in = b; byte_valid = 1'b1;
    if (!m_full) begin
      m_lane[m_idx] = b;
      if (m_idx == m_sel) m_full = 1; else m_idx++;
    end
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic strobe(input logic [2:0] nsel, input bit with_byte);
    width_sel = nsel; row_strobe = 1'b1;
    byte_valid = with_byte; byte_in = 8'hEE;
    if (m_full) begin
      m_drive = '0;
      for (int k = 0; k <= m_sel; k++) m_drive[k*8 +: 8] = m_lane[k];
    end
    exp_q.push_back(m_drive);
    m_sel = nsel; m_idx = 0; m_full = 0;
    @(negedge clk);
    row_strobe = 1'b0; byte_valid = 1'b0;
  endtask

  // monitor: pops one expected drive word per strobe (R5, R6, R9)
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && row_strobe) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("R5 unexpected strobe", seg_out, 64'hx);
        else chk("R5/R6/R9 seg_out after strobe", seg_out, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 seg_out reset", seg_out, 64'h0);
    chk_ctrl("R1 reset");

    // full 64-column row at reset width (R1 width 7)
    for (int i = 0; i < 8; i++) begin
      push_byte(8'h10 + 8'(i));
      chk_ctrl("R2/R3 wide row");
    end
    push_byte(8'hFF);               // ignored while full
    chk_ctrl("R4 byte while full");
    strobe(3'd1, 1'b0);
    chk_ctrl("R5 restart");

    // two-lane row, width_sel changed mid-row
    push_byte(8'hA1);
    width_sel = 3'd5;               // R7: must not lengthen this row
    chk_ctrl("R2 narrow row");
    push_byte(8'hA2);
    chk_ctrl("R7 full after two bytes");
    strobe(3'd0, 1'b0);             // R9 upper lanes cleared

    // single-lane row
    push_byte(8'h5C);
    chk_ctrl("R3 single lane");
    strobe(3'd3, 1'b0);

    // partial row then strobe: hold (R6)
    push_byte(8'h77);
    push_byte(8'h78);
    chk_ctrl("R2 partial");
    strobe(3'd3, 1'b0);
    chk_ctrl("R6 idx back to 0");

    // strobe with a byte in the same cycle (R8)
    strobe(3'd3, 1'b1);
    chk_ctrl("R8 byte dropped");
    for (int i = 0; i < 4; i++) push_byte(8'hC0 + 8'(i));
    chk_ctrl("R3 four lanes");
    strobe(3'd7, 1'b0);
    @(negedge clk);
    chk("R5 queue drained", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule